// File: doc/BRIEF.md
# Entropy Output Byte Stuffer

This block is the last stage of a baseline JPEG encoding path. Entropy-coded bytes from the upstream coder arrive as one time-multiplexed stream covering all three colour components. They are written into a small FIFO and leave through a valid/ready byte port. The output is a legal scan: every data byte of value 0xFF is followed at once by an inserted 0x00, so that a decoder never sees a false marker.

When the coder signals end of image, it may also hand over a partial last byte, left-justified, together with its count of valid bits. The block first lets the FIFO drain. It then fills the unused low bits of the partial byte with ones and emits it, stuffing it too if it has become 0xFF. Next come the end marker bytes 0xFF and 0xD9, which are never stuffed. A single-cycle done pulse closes the image, and the block is then ready for the next one. While a stuffed byte, a pad byte or a marker byte is on the output, the input side is held off.

Top module: `entropy_byte_stuffer`

## Requirements
- R1: After reset out_valid and done are low, and with eoi_valid low both in_ready and eoi_ready are high.
- R2: Data bytes other than 0xFF leave on out_data unchanged and in arrival order, one per out_valid/out_ready handshake.
- R3: Each data byte 0xFF is followed directly by one 0x00 byte. While that 0x00 is offered, in_ready is low and the FIFO keeps its contents.
- R4: The FIFO holds 16 bytes. With the output stalled, exactly 16 bytes are accepted and in_ready then stays low.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: eoi_ready is high only when the FIFO is empty and no stuffed byte is pending. When eoi_valid is high and the FIFO is empty, in_ready is low, so end of image wins over a byte offered in the same cycle.
- R7: When eoi_nbits is nonzero, a pad byte is emitted before the marker. Its top eoi_nbits bits come from eoi_bits[7:8-eoi_nbits] and every lower bit is 1. When eoi_nbits is 0, no pad byte is emitted.
- R8: A pad byte equal to 0xFF is followed by a stuffed 0x00.
- R9: After the last data, pad or stuff byte, the block emits 0xFF and then 0xD9, with no 0x00 after either.
- R10: done is high for exactly one cycle, in the cycle after the 0xD9 handshake. The block then accepts data and a new end of image again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Entropy-coded byte |
| eoi_valid | input | 1 | End-of-image request |
| eoi_ready | output | 1 | End-of-image request can be taken |
| eoi_bits | input | 8 | Partial last byte, left-justified |
| eoi_nbits | input | 3 | Number of valid bits in eoi_bits (0 = none) |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output stream byte |
| done | output | 1 | One-cycle pulse after the end marker is taken |

## Verification
Two events can land in the same cycle: an end-of-image request and a new data byte offered while the FIFO is empty. The bench raises both in the same cycle. It expects eoi_ready high and in_ready low, then expects the marker pair first and the held byte only after done, inside the next image. A second overlap is a 0xFF data byte ahead of end of image, where the stuffed 0x00 has to come out before the request is taken. A stall is also held over the stuffed byte, so the bench can check that the input is blocked while it is offered.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [2:0] {
      ST_DATA     = 3'd0,
      ST_STUFF    = 3'd1,
      ST_PAD      = 3'd2,
      ST_PADSTUFF = 3'd3,
      ST_MKHI     = 3'd4,
      ST_MKLO     = 3'd5
   } ebs_state_t;

endpackage

// File: rtl/ebs_fifo.sv
module ebs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0] cnt_q;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rd_q];
   assign full  = (cnt_q == CNT_MAX);
   assign empty = (cnt_q == '0);

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/ebs_pad.sv
module ebs_pad #(
   parameter int W        = 8,
   parameter bit PAD_ONES = 1'b1,
   localparam int NBW     = $clog2(W)
) (
   input  logic [W-1:0]   bits,
   input  logic [NBW-1:0] nbits,
   output logic [W-1:0]   padded
);
   logic [W-1:0] fill;

   assign fill = {W{1'b1}} >> nbits;

   generate
      if (PAD_ONES) begin : g_ones
         assign padded = bits | fill;
      end else begin : g_zeros
         assign padded = bits & ~fill;
      end
   endgenerate

endmodule

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
   import ebs_pkg::*;
#(
   parameter int            W        = 8,
   parameter logic [W-1:0]  MARK     = 8'hFF,
   parameter logic [W-1:0]  END_CODE = 8'hD9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_head,
   output logic         fifo_pop,
   input  logic         eoi_valid,
   output logic         eoi_ready,
   input  logic         eoi_has_bits,
   input  logic [W-1:0] pad_byte,
   output logic         in_allow,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         done
);
   ebs_state_t   st_q;
   logic [W-1:0] pad_q;
   logic         fire;
   logic         eoi_take;

   always_comb begin
      out_valid = 1'b1;
      out_data  = '0;
      unique case (st_q)
         ST_DATA: begin
            out_valid = !fifo_empty;
            out_data  = fifo_head;
         end
         ST_STUFF, ST_PADSTUFF: out_data = '0;
         ST_PAD:                out_data = pad_q;
         ST_MKHI:               out_data = MARK;
         ST_MKLO:               out_data = END_CODE;
         default:               out_data = '0;
      endcase
   end

   assign fire      = out_valid && out_ready;
   assign fifo_pop  = (st_q == ST_DATA) && fire;
   assign eoi_ready = (st_q == ST_DATA) && fifo_empty;
   assign eoi_take  = eoi_valid && eoi_ready;
   assign in_allow  = (st_q == ST_DATA) && !(eoi_valid && fifo_empty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_DATA;
         pad_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_DATA: begin
               if (eoi_take) begin
                  pad_q <= pad_byte;
                  st_q  <= eoi_has_bits ? ST_PAD : ST_MKHI;
               end else if (fifo_pop && fifo_head == MARK) begin
                  st_q <= ST_STUFF;
               end
            end
            ST_STUFF:    if (fire) st_q <= ST_DATA;
            ST_PAD:      if (fire) st_q <= (pad_q == MARK) ? ST_PADSTUFF : ST_MKHI;
            ST_PADSTUFF: if (fire) st_q <= ST_MKHI;
            ST_MKHI:     if (fire) st_q <= ST_MKLO;
            ST_MKLO: begin
               if (fire) begin
                  st_q <= ST_DATA;
                  done <= 1'b1;
               end
            end
            default: st_q <= ST_DATA;
         endcase
      end
   end

   a_r3_stuff_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && fifo_head == MARK) |=> (out_valid && out_data == '0));
   a_r8_pad_stuffed: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD && fire && out_data == MARK) |=> (out_valid && out_data == '0));
   a_r9_marker_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MKHI && fire) |=> (out_valid && out_data == END_CODE));
   a_r10_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(st_q == ST_MKLO && fire));
   a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/entropy_byte_stuffer.sv
module entropy_byte_stuffer #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int MARK_CODE = 'hFF,
   parameter int END_CODE  = 'hD9,
   parameter bit PAD_ONES  = 1'b1,
   localparam int NBW      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              eoi_valid,
   output logic              eoi_ready,
   input  logic [DATA_W-1:0] eoi_bits,
   input  logic [NBW-1:0]    eoi_nbits,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   localparam logic [DATA_W-1:0] MARK_B = MARK_CODE[DATA_W-1:0];
   localparam logic [DATA_W-1:0] END_B  = END_CODE[DATA_W-1:0];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("entropy_byte_stuffer: DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("entropy_byte_stuffer: DATA_W must be at least 2");
      end
      if (MARK_CODE == 0) begin : g_bad_mark
         $error("entropy_byte_stuffer: MARK_CODE must differ from the stuff value");
      end
   endgenerate

   logic              f_full, f_empty, f_pop, f_push;
   logic [DATA_W-1:0] f_head, pad_byte;
   logic              in_allow;

   assign in_ready = in_allow && !f_full;
   assign f_push   = in_valid && in_ready;

   ebs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .din   (in_data),
      .pop   (f_pop),
      .dout  (f_head),
      .full  (f_full),
      .empty (f_empty)
   );

   ebs_pad #(.W(DATA_W), .PAD_ONES(PAD_ONES)) u_pad (
      .bits   (eoi_bits),
      .nbits  (eoi_nbits),
      .padded (pad_byte)
   );

   ebs_ctrl #(.W(DATA_W), .MARK(MARK_B), .END_CODE(END_B)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .fifo_empty   (f_empty),
      .fifo_head    (f_head),
      .fifo_pop     (f_pop),
      .eoi_valid    (eoi_valid),
      .eoi_ready    (eoi_ready),
      .eoi_has_bits (eoi_nbits != '0),
      .pad_byte     (pad_byte),
      .in_allow     (in_allow),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_data     (out_data),
      .done         (done)
   );

   a_r6_eoi_beats_data: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && eoi_ready) |-> !(in_valid && in_ready));
   a_r3_no_intake_off_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_data == '0 && $past(out_valid && out_ready && out_data == MARK_B))
      |-> !in_ready);

endmodule

// File: tb/entropy_byte_stuffer_bench.sv
module entropy_byte_stuffer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, eoi_valid = 1'b0;
   logic [7:0] in_data = '0, eoi_bits = '0;
   logic [2:0] eoi_nbits = '0;
   logic       in_ready, eoi_ready, out_valid, out_ready, done;
   logic [7:0] out_data;

   int checks = 0, errors = 0;
   int rdy_mode = 0;          // 0 always, 1 pseudo-random, 2 manual
   logic rdy_man = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   logic [7:0] got[$], exp_q[$];
   int done_cnt = 0;
   logic done_prev = 1'b0;

   always #4 clk = ~clk;

   entropy_byte_stuffer u_entropy_byte_stuffer (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
      .eoi_bits(eoi_bits), .eoi_nbits(eoi_nbits),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .done(done));

   always @(posedge clk) begin
      #1 lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   end
   assign out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : rdy_man;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) got.push_back(out_data);
         if (done) begin
            done_cnt++;
            chk(!done_prev, "R10 done longer than one cycle", 1, 0);
            chk(got.size() > 0 && got[got.size()-1] == 8'hD9, "R10 done not after end code",
                got.size() > 0 ? int'(got[got.size()-1]) : -1, 'hD9);
         end
         done_prev = done;
      end
   end

   task automatic push(input logic [7:0] b);
      @(posedge clk); #2;
      in_valid = 1'b1; in_data = b;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_valid = 1'b0;
   endtask

   task automatic send_eoi(input logic [7:0] bits, input logic [2:0] n);
      @(posedge clk); #2;
      eoi_valid = 1'b1; eoi_bits = bits; eoi_nbits = n;
      do @(negedge clk); while (!eoi_ready);
      @(posedge clk); #2;
      eoi_valid = 1'b0;
   endtask

   task automatic wait_done(input int target);
      int k = 0;
      while (done_cnt < target && k < 3000) begin
         @(negedge clk); k++;
      end
      chk(done_cnt >= target, "R10 done pulse missing", done_cnt, target);
   endtask

   task automatic compare(input string req);
      chk(got.size() == exp_q.size(), {req, " stream length"}, got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got.size(); i++)
         chk(got[i] == exp_q[i], {req, " stream byte"}, got[i], exp_q[i]);
      got.delete(); exp_q.delete();
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
      chk(!done, "R1 done after reset", done, 0);
      chk(in_ready, "R1 in_ready after reset", in_ready, 1);
      chk(eoi_ready, "R1 eoi_ready after reset", eoi_ready, 1);
   endtask

   task automatic t_plain();
      int base = done_cnt;
      rdy_mode = 0;
      push(8'h12); push(8'h34); push(8'h56);
      send_eoi(8'h00, 3'd0);
      wait_done(base + 1);
      exp_q = '{8'h12, 8'h34, 8'h56, 8'hFF, 8'hD9};
      compare("R2 R9 plain");
      @(negedge clk);
      chk(eoi_ready && in_ready, "R10 ready again after done", {eoi_ready, in_ready}, 3);
   endtask

   task automatic t_stuff_random();
      int base = done_cnt;
      rdy_mode = 1;
      push(8'hFF); push(8'h00); push(8'hFF); push(8'hFF); push(8'h7A);
      send_eoi(8'hA0, 3'd3);
      wait_done(base + 1);
      exp_q = '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h7A, 8'hBF, 8'hFF, 8'hD9};
      compare("R3 R7 stuff with stalls");
      rdy_mode = 0;
   endtask

   task automatic t_pad_ff();
      int base = done_cnt;
      rdy_mode = 0;
      push(8'h3C);
      send_eoi(8'hF0, 3'd4);
      wait_done(base + 1);
      exp_q = '{8'h3C, 8'hFF, 8'h00, 8'hFF, 8'hD9};
      compare("R8 padded 0xFF");
      base = done_cnt;
      send_eoi(8'h40, 3'd1);
      wait_done(base + 1);
      exp_q = '{8'h7F, 8'hFF, 8'hD9};
      compare("R7 one-bit pad");
   endtask

   task automatic t_stuff_stall();
      int base = done_cnt;
      rdy_mode = 2; rdy_man = 1'b0;
      push(8'hFF); push(8'h11);
      repeat (2) @(negedge clk);
      chk(out_valid && out_data == 8'hFF, "R5 held head byte", out_data, 'hFF);
      @(posedge clk); #2 rdy_man = 1'b1;
      @(posedge clk); #2 rdy_man = 1'b0;
      @(negedge clk);
      chk(out_valid && out_data == 8'h00, "R3 stuffed byte offered", out_data, 0);
      chk(!in_ready, "R3 input held during stuff", in_ready, 0);
      chk(!eoi_ready, "R6 eoi held during stuff", eoi_ready, 0);
      @(negedge clk);
      chk(out_data == 8'h00, "R5 stuffed byte stable", out_data, 0);
      @(posedge clk); #2 rdy_man = 1'b1;
      push(8'h22);
      send_eoi(8'h00, 3'd0);
      wait_done(base + 1);
      exp_q = '{8'hFF, 8'h00, 8'h11, 8'h22, 8'hFF, 8'hD9};
      compare("R3 stalled stuff");
      rdy_mode = 0;
   endtask

   task automatic t_full();
      int acc = 0;
      int base = done_cnt;
      rdy_mode = 2; rdy_man = 1'b0;
      @(posedge clk); #2;
      in_valid = 1'b1; in_data = 8'd1;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (in_valid && in_ready) acc++;
         @(posedge clk); #2;
         in_data = 8'(acc + 1);
      end
      @(negedge clk);
      chk(acc == 16, "R4 bytes accepted when stalled", acc, 16);
      chk(!in_ready, "R4 in_ready low when full", in_ready, 0);
      chk(!eoi_ready, "R6 eoi_ready low with data queued", eoi_ready, 0);
      chk(out_valid && out_data == 8'd1, "R5 head held while stalled", out_data, 1);
      @(posedge clk); #2;
      in_valid = 1'b0; rdy_man = 1'b1;
      send_eoi(8'h00, 3'd0);
      wait_done(base + 1);
      for (int i = 1; i <= 16; i++) exp_q.push_back(8'(i));
      exp_q.push_back(8'hFF); exp_q.push_back(8'hD9);
      compare("R4 full FIFO");
      rdy_mode = 0;
   endtask

   task automatic t_collide();
      int base = done_cnt;
      rdy_mode = 0;
      @(posedge clk); #2;
      in_valid = 1'b1; in_data = 8'h55;
      eoi_valid = 1'b1; eoi_nbits = 3'd0; eoi_bits = 8'h00;
      @(negedge clk);
      chk(eoi_ready, "R6 eoi_ready on collision", eoi_ready, 1);
      chk(!in_ready, "R6 in_ready low on collision", in_ready, 0);
      @(posedge clk); #2;
      eoi_valid = 1'b0;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #2;
      in_valid = 1'b0;
      wait_done(base + 1);
      send_eoi(8'h00, 3'd0);
      wait_done(base + 2);
      exp_q = '{8'hFF, 8'hD9, 8'h55, 8'hFF, 8'hD9};
      compare("R6 R10 collision");
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_plain();
      t_stuff_random();
      t_pad_ff();
      t_stuff_stall();
      t_full();
      t_collide();
      repeat (4) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule